// File: doc/BRIEF.md
# SDRAM Timing Word Encoder

This block converts SDRAM timing settings into the two control words a memory controller expects: a packed timing word and a refresh interval word. The settings are given in nanoseconds, together with the bus clock period in tenths of a nanosecond. A one-cycle `start` pulse captures every input. A single sequential restoring divider then works through seven divisions, one after another:

- five nanosecond-to-clock conversions;
- the bus frequency in kHz;
- the final refresh scaling.

Each clock count is clamped to the legal range of its field. A field that is out of range takes a fixed fallback code. When the `cfg_valid` flag is low at the start pulse, no arithmetic is done. Instead, one of two fixed word pairs is selected by bus speed, and it is ready one cycle later.

Both words hold, and `valid` stays high, until the next start pulse. Because every input is captured at the start pulse, the inputs may change freely while a computation is running.

Top module: `sdram_tmg_enc`

## Requirements
- R1: While reset is asserted and after it is released, `valid` is 0 and both words are 0 until the first computation completes.
- R2: All inputs are captured on the clock edge that samples `start` high. Input changes after that edge do not affect the result. A new `start` while busy restarts the computation with the new inputs.
- R3: With `cfg_valid`=1, a nanosecond value converts to clocks as floor((ns*10 + period_x10) / period_x10). `valid` rises 7*(DIV_W+1)+1 rising edges after the start edge, which is 400 edges with the default DIV_W=56.
- R4: The CAS latency field, at timing word bits 24:23, encodes 1 for latency below 2, encodes 3 for latency above 4, and otherwise encodes latency-1.
- R5: The precharge-to-activate field (bits 19:18), the command-to-precharge field (bits 17:16) and the RAS-to-CAS field (bits 1:0) each encode clocks-1 when clocks is 2..4 inclusive. Otherwise each encodes 3.
- R6: The leadoff field, at bits 15:14, encodes clocks-1 when clocks is 2..4 inclusive, and otherwise encodes 1.
- R7: The refresh-to-activate field, at bits 4:2, encodes clocks-4 when clocks is 4..10 inclusive, and otherwise encodes 6.
- R8: With `cfg_valid`=1, the refresh word is computed as follows:
  - the refresh count is floor(floor(floor(refresh_ms*1e6 / 2^row_bits) * floor(1e7/period_x10)) / 1e6);
  - the count is ANDed with 0x3FF8;
  - the result is shifted left by 16.
- R9: With `cfg_valid`=0, `valid` rises one rising edge after the start edge, and the result depends on the bus period:
  - period_x10 below 100: the timing word is 0x01074015 and the refresh word is 0x07F00000;
  - otherwise: the timing word is 0x0086400D and the refresh word is 0x05F00000.
- R10: `valid` is 0 after the start edge. Once `valid` is high, it and both words hold unchanged until the next start.
- R11: Timing word bits not belonging to a field (31:25, 22:20, 13:5) are 0. Refresh word bits 31:30 and 18:0 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin a computation |
| cfg_valid | input | 1 | 1: compute from the timing inputs; 0: use the speed-selected preset words |
| period_x10 | input | PER_W | Bus clock period in units of 0.1 ns (nonzero) |
| cas_lat | input | 4 | CAS latency in clocks |
| t_pre_act_ns | input | NS_W | Precharge-to-activate time, ns |
| t_cmd_pre_ns | input | NS_W | Command-to-precharge time, ns |
| t_lead_ns | input | NS_W | Leadoff time, ns |
| t_ref_act_ns | input | NS_W | Refresh-to-activate time, ns |
| t_ras_cas_ns | input | NS_W | RAS-to-CAS time, ns |
| row_bits | input | 5 | Number of row address bits |
| refresh_ms | input | MS_W | Refresh period, ms |
| valid | output | 1 | Words are complete and stable |
| timing_word | output | 32 | Packed timing control word |
| refresh_word | output | 32 | Refresh interval word |

## Verification
Results become due at one of two fixed distances from the edge that samples `start`:

- with `cfg_valid`=1, they are due 400 rising edges later;
- with `cfg_valid`=0, they are due one rising edge later.

The bench drives on falling edges and counts rising edges from the start edge. It samples `valid` at the falling edge after each of them and compares the count at which `valid` first reads 1 against the expected figure. Only then are the words compared, and both are compared again after several further cycles to confirm they held. Expected words come from a bench-side arithmetic model. The bench sweeps bus periods and clock counts across every clamp boundary, half the runs scrambling the inputs after the start edge.

// File: rtl/sdram_tmg_enc.sv
module sdram_tmg_enc #(
  parameter int NS_W       = 8,
  parameter int PER_W      = 16,
  parameter int MS_W       = 8,
  parameter int DIV_W      = 56,
  parameter int CAS_LSB    = 23,
  parameter int PRE_LSB    = 18,
  parameter int CMD_LSB    = 16,
  parameter int LEAD_LSB   = 14,
  parameter int RFA_LSB    = 2,
  parameter int RCD_LSB    = 0,
  parameter int FAST_PER   = 100,
  parameter logic [31:0] FAST_TW = 32'h0107_4015,
  parameter logic [31:0] SLOW_TW = 32'h0086_400D,
  parameter logic [31:0] FAST_RW = 32'h07F0_0000,
  parameter logic [31:0] SLOW_RW = 32'h05F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_valid,
  input  logic [PER_W-1:0] period_x10,
  input  logic [3:0]       cas_lat,
  input  logic [NS_W-1:0]  t_pre_act_ns,
  input  logic [NS_W-1:0]  t_cmd_pre_ns,
  input  logic [NS_W-1:0]  t_lead_ns,
  input  logic [NS_W-1:0]  t_ref_act_ns,
  input  logic [NS_W-1:0]  t_ras_cas_ns,
  input  logic [4:0]       row_bits,
  input  logic [MS_W-1:0]  refresh_ms,
  output logic             valid,
  output logic [31:0]      timing_word,
  output logic [31:0]      refresh_word
);
  localparam int DVR_W = 24;
  localparam int CNT_W = $clog2(DIV_W + 1);
  localparam int N_OPS = 7;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_DONE} st_t;
  st_t st;

  logic [2:0]       op;
  logic [CNT_W-1:0] cnt;
  logic [DVR_W-1:0] rem, dvr;
  logic [DIV_W-1:0] q;

  logic             l_cfg;
  logic [PER_W-1:0] l_per;
  logic [3:0]       l_cas;
  logic [NS_W-1:0]  l_ns [5];
  logic [4:0]       l_rows;
  logic [MS_W-1:0]  l_ms;

  logic [3:0]       clk_r [5];
  logic [DIV_W-1:0] fk;
  logic [13:0]      rcnt;

  logic [DIV_W-1:0] dvd_in, scaled;
  logic [DVR_W-1:0] dvr_in;
  logic [DVR_W:0]   tmp;
  logic             ge;
  logic [DVR_W-1:0] rem_nx;
  logic [DIV_W-1:0] q_nx;
  logic [3:0]       q_sat;

  assign scaled = (DIV_W'(l_ms) * DIV_W'(32'd1_000_000)) >> l_rows;

  always_comb begin
    dvd_in = '0;
    dvr_in = DVR_W'(l_per);
    if (op < 3'd5) begin
      dvd_in = DIV_W'(l_ns[op]) * DIV_W'(10) + DIV_W'(l_per);
    end else if (op == 3'd5) begin
      dvd_in = DIV_W'(32'd10_000_000);
    end else begin
      dvd_in = scaled * fk;
      dvr_in = DVR_W'(32'd1_000_000);
    end
  end

  assign tmp    = {rem, q[DIV_W-1]};
  assign ge     = tmp >= {1'b0, dvr};
  assign rem_nx = ge ? DVR_W'(tmp - {1'b0, dvr}) : tmp[DVR_W-1:0];
  assign q_nx   = {q[DIV_W-2:0], ge};
  assign q_sat  = (|q_nx[DIV_W-1:4]) ? 4'hF : q_nx[3:0];

  function automatic logic [1:0] enc_mid(input logic [3:0] c, input logic [1:0] fb);
    return (c >= 4'd2 && c <= 4'd4) ? 2'(c - 4'd1) : fb;
  endfunction

  logic [1:0] e_cas, e_pre, e_cmd, e_lead, e_rcd;
  logic [2:0] e_rfa;
  logic [31:0] tw_calc, rw_calc;

  assign e_cas  = (l_cas < 4'd2) ? 2'd1 : (l_cas > 4'd4) ? 2'd3 : 2'(l_cas - 4'd1);
  assign e_pre  = enc_mid(clk_r[0], 2'd3);
  assign e_cmd  = enc_mid(clk_r[1], 2'd3);
  assign e_lead = enc_mid(clk_r[2], 2'd1);
  assign e_rfa  = (clk_r[3] >= 4'd4 && clk_r[3] <= 4'd10) ? 3'(clk_r[3] - 4'd4) : 3'd6;
  assign e_rcd  = enc_mid(clk_r[4], 2'd3);

  always_comb begin
    tw_calc = '0;
    tw_calc[CAS_LSB  +: 2] = e_cas;
    tw_calc[PRE_LSB  +: 2] = e_pre;
    tw_calc[CMD_LSB  +: 2] = e_cmd;
    tw_calc[LEAD_LSB +: 2] = e_lead;
    tw_calc[RFA_LSB  +: 3] = e_rfa;
    tw_calc[RCD_LSB  +: 2] = e_rcd;
  end

  assign rw_calc = 32'(rcnt & 14'h3FF8) << 16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      op           <= '0;
      cnt          <= '0;
      rem          <= '0;
      dvr          <= '0;
      q            <= '0;
      l_cfg        <= 1'b0;
      l_per        <= '0;
      l_cas        <= '0;
      l_rows       <= '0;
      l_ms         <= '0;
      fk           <= '0;
      rcnt         <= '0;
      valid        <= 1'b0;
      timing_word  <= '0;
      refresh_word <= '0;
      for (int i = 0; i < 5; i++) begin
        l_ns[i]  <= '0;
        clk_r[i] <= '0;
      end
    end else if (start) begin
      l_cfg   <= cfg_valid;
      l_per   <= period_x10;
      l_cas   <= cas_lat;
      l_ns[0] <= t_pre_act_ns;
      l_ns[1] <= t_cmd_pre_ns;
      l_ns[2] <= t_lead_ns;
      l_ns[3] <= t_ref_act_ns;
      l_ns[4] <= t_ras_cas_ns;
      l_rows  <= row_bits;
      l_ms    <= refresh_ms;
      op      <= '0;
      valid   <= 1'b0;
      st      <= cfg_valid ? S_LOAD : S_DONE;
    end else begin
      case (st)
        S_LOAD: begin
          q   <= dvd_in;
          dvr <= dvr_in;
          rem <= '0;
          cnt <= CNT_W'(DIV_W);
          st  <= S_RUN;
        end
        S_RUN: begin
          q   <= q_nx;
          rem <= rem_nx;
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            case (op)
              3'd0: clk_r[0] <= q_sat;
              3'd1: clk_r[1] <= q_sat;
              3'd2: clk_r[2] <= q_sat;
              3'd3: clk_r[3] <= q_sat;
              3'd4: clk_r[4] <= q_sat;
              3'd5: fk       <= q_nx;
              default: rcnt  <= q_nx[13:0];
            endcase
            if (op == 3'(N_OPS - 1)) st <= S_DONE;
            else begin
              op <= op + 1'b1;
              st <= S_LOAD;
            end
          end
        end
        S_DONE: begin
          valid <= 1'b1;
          st    <= S_IDLE;
          if (l_cfg) begin
            timing_word  <= tw_calc;
            refresh_word <= rw_calc;
          end else if (l_per < PER_W'(FAST_PER)) begin
            timing_word  <= FAST_TW;
            refresh_word <= FAST_RW;
          end else begin
            timing_word  <= SLOW_TW;
            refresh_word <= SLOW_RW;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_tmg_enc_chk.sv
module sdram_tmg_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cfg_valid,
  input logic        valid,
  input logic [31:0] timing_word,
  input logic [31:0] refresh_word
);
  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !start |=> valid && $stable(timing_word) && $stable(refresh_word));

  // R9
  preset_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cfg_valid ##1 !start |=> valid);

  // R11
  tw_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> timing_word[31:25] == '0 && timing_word[22:20] == '0 && timing_word[13:5] == '0);

  // R11
  rw_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> refresh_word[31:30] == '0 && refresh_word[18:0] == '0);

  // R7
  rfa_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> timing_word[4:2] <= 3'd6);

  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !valid);
endmodule

bind sdram_tmg_enc sdram_tmg_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_valid(cfg_valid),
  .valid(valid), .timing_word(timing_word), .refresh_word(refresh_word)
);

// File: tb/sdram_tmg_enc_bench.sv
module sdram_tmg_enc_bench;
  localparam int DIV_W = 56;
  localparam int LAT_CFG = 7 * (DIV_W + 1) + 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        cfg_valid = 0;
  logic [15:0] period_x10 = 16'd100;
  logic [3:0]  cas_lat = 0;
  logic [7:0]  t_pre_act_ns = 0, t_cmd_pre_ns = 0, t_lead_ns = 0, t_ref_act_ns = 0, t_ras_cas_ns = 0;
  logic [4:0]  row_bits = 0;
  logic [7:0]  refresh_ms = 0;
  logic        valid;
  logic [31:0] timing_word, refresh_word;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sdram_tmg_enc u_sdram_tmg_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_valid(cfg_valid),
    .period_x10(period_x10), .cas_lat(cas_lat),
    .t_pre_act_ns(t_pre_act_ns), .t_cmd_pre_ns(t_cmd_pre_ns), .t_lead_ns(t_lead_ns),
    .t_ref_act_ns(t_ref_act_ns), .t_ras_cas_ns(t_ras_cas_ns),
    .row_bits(row_bits), .refresh_ms(refresh_ms),
    .valid(valid), .timing_word(timing_word), .refresh_word(refresh_word)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint clks(input longint ns, input longint p);
    return (ns * 10 + p) / p;
  endfunction

  function automatic longint mid(input longint c, input longint fb);
    return (c >= 2 && c <= 4) ? c - 1 : fb;
  endfunction

  function automatic longint exp_tw(input longint p, input longint cas,
      input longint a, input longint b, input longint l, input longint r, input longint d);
    longint ce, rf;
    ce = (cas < 2) ? 1 : (cas > 4) ? 3 : cas - 1;
    rf = (clks(r, p) >= 4 && clks(r, p) <= 10) ? clks(r, p) - 4 : 6;
    return (ce << 23) | (mid(clks(a, p), 3) << 18) | (mid(clks(b, p), 3) << 16) |
           (mid(clks(l, p), 1) << 14) | (rf << 2) | mid(clks(d, p), 3);
  endfunction

  function automatic longint exp_rw(input longint p, input longint rows, input longint ms);
    longint fk, cnt;
    fk  = 10_000_000 / p;
    cnt = (((ms * 1_000_000) >> rows) * fk) / 1_000_000;
    return (cnt & 64'h3FF8) << 16;
  endfunction

  task automatic run(input bit cfg, input int p, input int cas, input int a, input int b,
                     input int l, input int r, input int d, input int rows, input int ms,
                     input bit scramble);
    longint etw, erw;
    int c;
    @(negedge clk);
    cfg_valid = cfg; period_x10 = 16'(p); cas_lat = 4'(cas);
    t_pre_act_ns = 8'(a); t_cmd_pre_ns = 8'(b); t_lead_ns = 8'(l);
    t_ref_act_ns = 8'(r); t_ras_cas_ns = 8'(d); row_bits = 5'(rows); refresh_ms = 8'(ms);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check("R10 valid low after start", longint'(valid), 0);
    if (scramble) begin
      cfg_valid = ~cfg; period_x10 = 16'(p + 37); cas_lat = ~cas_lat;
      t_pre_act_ns = 8'hFF; t_cmd_pre_ns = 8'h00; t_lead_ns = 8'h55;
      t_ref_act_ns = 8'hAA; t_ras_cas_ns = 8'h01; row_bits = 5'd3; refresh_ms = 8'd200;
    end
    c = 0;
    do begin
      @(posedge clk);
      c++;
      @(negedge clk);
    end while (!valid && c < 2000);
    if (cfg) begin
      etw = exp_tw(p, cas, a, b, l, r, d);
      erw = exp_rw(p, rows, ms);
      check("R3 configured latency", c, LAT_CFG);
      check("R4 R5 R6 R7 timing word", longint'(timing_word), etw);
      check("R8 refresh word", longint'(refresh_word), erw);
    end else begin
      etw = (p < 100) ? 64'h0107_4015 : 64'h0086_400D;
      erw = (p < 100) ? 64'h07F0_0000 : 64'h05F0_0000;
      check("R9 preset latency", c, 1);
      check("R9 preset timing word", longint'(timing_word), etw);
      check("R9 preset refresh word", longint'(refresh_word), erw);
    end
    if (scramble) check("R2 captured inputs", longint'(timing_word), etw);
    period_x10 = 16'd7; cas_lat = 4'd9;
    repeat (5) @(negedge clk);
    check("R10 hold valid", longint'(valid), 1);
    check("R10 hold timing word", longint'(timing_word), etw);
    check("R10 hold refresh word", longint'(refresh_word), erw);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pers [3];
    pers[0] = 75; pers[1] = 100; pers[2] = 150;
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(valid), 0);
    check("R1 reset timing word", longint'(timing_word), 0);
    check("R1 reset refresh word", longint'(refresh_word), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", longint'(valid), 0);
    check("R1 idle timing word", longint'(timing_word), 0);

    for (int pi = 0; pi < 3; pi++) begin
      for (int v = 0; v < 14; v++) begin
        int p;
        p = pers[pi];
        run(1'b1, p, v % 7,
            v * p / 10, ((v + 3) % 14) * p / 10, ((v + 6) % 14) * p / 10 + 1,
            ((v + 1) % 14) * p / 10, ((v + 9) % 14) * p / 10,
            10 + v % 4, 32 + 8 * (v % 5), v[0]);
      end
    end

    for (int k = 0; k < 16; k++) run(1'b1, 100, k, 20, 20, 20, 70, 20, 12, 64, 1'b0);

    run(1'b0, 99, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    run(1'b0, 100, 3, 9, 9, 9, 9, 9, 13, 64, 1'b1);
    run(1'b0, 50, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    run(1'b0, 200, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);

    // R2: restart while busy, result follows second start
    @(negedge clk);
    cfg_valid = 1; period_x10 = 16'd100; cas_lat = 4'd2;
    t_pre_act_ns = 8'd90; start = 1;
    @(negedge clk);
    start = 0;
    repeat (100) @(negedge clk);
    run(1'b1, 75, 3, 15, 22, 8, 60, 30, 13, 64, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule